// File: doc/BRIEF.md
# Multi-lane SPI master

A synchronous serial master that moves 8-bit words over one, two or four data lanes, most significant bits first. A small register-style host port loads a 4-entry transmit FIFO, drains a 4-entry receive FIFO, and selects the lane mode, the transfer direction and the serial clock rate. The block generates the serial clock (idle low; outputs change on its falling edge, inputs are sampled on its rising edge) and an active-low chip select that stays asserted for a whole burst of back-to-back words.

The single-lane modes drive lane 0 and sample lane 1. In legacy mode every word is full-duplex. In advanced mode the direction bit decides whether received bits are stored. The dual-lane and quad-lane modes are half-duplex. A transmit burst drives all active lanes, and the receive FIFO stores nothing. A receive burst releases every lane, and a receive-count register sets how many words are clocked in. The transmit FIFO is left untouched.

The controller is a four-state machine. `S_IDLE` goes to `S_LOW` when work is pending, which loads a word. `S_LOW` goes to `S_HIGH` after one half-period, which is the rising edge where the inputs are sampled. `S_HIGH` goes back to `S_LOW` after one half-period, which is the falling edge where the next lanes are shifted out. On the last clock of a word, `S_HIGH` returns to `S_LOW` if more work is pending, which loads the next word. Otherwise it goes to `S_TAIL`. `S_TAIL` goes to `S_IDLE` after one half-period, which releases chip select.

Top module: `mlspi_master`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the output enables are 4'b0001, and the status word reads zero.
- R2: Register address 0 is control: bits [1:0] mode (0 legacy, 1 advanced, 2 dual, 3 quad), bit 2 direction (1 transmit, 0 receive), bits [15:8] half-period in system clocks (0 acts as 1). Address 1 writes the transmit FIFO and reads (and pops) the receive FIFO. Address 2 is the receive count. Address 3 reads status: [2:0] transmit count, [5:3] receive count, [6] transmit overflow, [7] receive overflow, [8] busy. A write to address 3 clears both overflow flags.
- R3: Legacy mode shifts each transmit word out MSB first on lane 0 over 8 serial clocks and stores the 8 bits sampled on lane 1, whatever the direction bit.
- R4: Advanced mode shifts words out on lane 0 over 8 clocks. It stores the bits from lane 1 only when the direction is receive.
- R5: Dual mode takes 4 clocks per word; lane 1 carries the higher and lane 0 the lower bit of each pair (0x55 gives pairs 01,01,01,01).
- R6: Quad mode takes 2 clocks per word with lane 3 carrying the highest bit of each nibble.
- R7: In dual or quad mode with receive selected, a burst starts only when the receive count is non-zero. The count drops by one per word. The transmit FIFO is neither popped nor used to start a burst.
- R8: In dual or quad mode with transmit selected, the receive FIFO stores nothing.
- R9: Output enables are 4'b0001 in single-lane modes, 4'b0011 for dual transmit, 4'b1111 for quad transmit and 4'b0000 for dual or quad receive.
- R10: Chip select stays low across back-to-back words and rises one half-period after the last falling serial clock edge.
- R11: Each serial clock phase lasts the programmed half-period, so a burst of n clocks holds chip select low for (2n+1) half-periods.
- R12: Both FIFOs hold 4 words. A write into a full FIFO is dropped and sets that FIFO's sticky overflow flag.
- R13: Lane outputs change only on the falling serial clock edge, and lane inputs are sampled on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive FIFO at address 1) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_dout | output | 4 | Lane output values |
| spi_oe | output | 4 | Lane output enables |
| spi_din | input | 4 | Lane input values |

## Verification
The bench builds the block with its default parameters: 4-entry FIFOs, an 8-bit half-period field and a 16-bit host word. The FIFOs are shallow, so five host writes reach both overflow paths. Half-periods of 0 to 3 keep every mode's burst to a few dozen cycles, so every lane width and direction can be run against a lane-accurate slave model, including multi-word bursts, receive-count draining and the zero-divisor case.

// File: rtl/mlspi_pkg.sv
package mlspi_pkg;

    typedef enum logic [1:0] {
        MODE_LEGACY = 2'd0,
        MODE_ADV    = 2'd1,
        MODE_DUAL   = 2'd2,
        MODE_QUAD   = 2'd3
    } lane_mode_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LOW,
        S_HIGH,
        S_TAIL
    } phase_e;

    localparam logic [1:0] A_CTRL  = 2'd0;
    localparam logic [1:0] A_DATA  = 2'd1;
    localparam logic [1:0] A_RXCNT = 2'd2;
    localparam logic [1:0] A_STAT  = 2'd3;

    function automatic logic is_hd(lane_mode_e m);
        return (m == MODE_DUAL) || (m == MODE_QUAD);
    endfunction

    function automatic logic [2:0] last_clk(lane_mode_e m);
        unique case (m)
            MODE_QUAD: return 3'd1;
            MODE_DUAL: return 3'd3;
            default:   return 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/mlspi_fifo.sv
module mlspi_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    input  logic          ovf_clr,
    output logic          ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push_ok) - CW'(pop_ok);
            if (ovf_clr)             ovf <= 1'b0;
            else if (push && full)   ovf <= 1'b1;
        end
    end

    // R12
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R12
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !ovf_clr) |=> (ovf && $stable(count) || $past(pop)));

endmodule

// File: rtl/mlspi_engine.sv
module mlspi_engine
    import mlspi_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lane_mode_e        cfg_mode,
    input  logic              cfg_tx,
    input  logic [HALF_W-1:0] cfg_half,
    input  logic              tx_empty,
    input  logic [7:0]        tx_data,
    output logic              tx_pop,
    input  logic              rxcnt_nz,
    output logic              rxcnt_dec,
    output logic              rx_push,
    output logic [7:0]        rx_data,
    output logic              busy,
    output logic              sck,
    output logic              cs_n,
    output logic [3:0]        dout,
    output logic [3:0]        oe,
    input  logic [3:0]        din
);
    phase_e            state_q, nxt;
    lane_mode_e        cur_mode, sel_mode;
    logic              cur_tx, sel_tx;
    logic [HALF_W-1:0] cur_half, half_eff, tmr_q;
    logic [2:0]        bitc_q;
    logic [7:0]        tx_sh, rx_sh;
    logic              from_tx_cfg, from_tx_cur, ld_from_tx;
    logic              start, more, tick, last, cap;
    logic              ld_idle, ld_cont, ld_any;

    assign from_tx_cfg = !(is_hd(cfg_mode) && !cfg_tx);
    assign from_tx_cur = !(is_hd(cur_mode) && !cur_tx);
    assign start       = from_tx_cfg ? !tx_empty : rxcnt_nz;
    assign more        = from_tx_cur ? !tx_empty : rxcnt_nz;
    assign half_eff    = (cfg_half == '0) ? HALF_W'(1) : cfg_half;
    assign tick        = (tmr_q == cur_half - 1'b1);
    assign last        = (bitc_q == last_clk(cur_mode));
    assign cap         = (cur_mode == MODE_LEGACY) || !cur_tx;
    assign ld_any      = ld_idle || ld_cont;
    assign ld_from_tx  = ld_idle ? from_tx_cfg : from_tx_cur;
    assign tx_pop      = ld_any && ld_from_tx;
    assign rxcnt_dec   = ld_any && !ld_from_tx;
    assign rx_data     = rx_sh;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= nxt;
    end

    // transitions
    always_comb begin
        nxt     = state_q;
        ld_idle = 1'b0;
        ld_cont = 1'b0;
        rx_push = 1'b0;
        unique case (state_q)
            S_IDLE: if (start) begin
                nxt     = S_LOW;
                ld_idle = 1'b1;
            end
            S_LOW:  if (tick) nxt = S_HIGH;
            S_HIGH: if (tick) begin
                if (last) begin
                    rx_push = cap;
                    if (more) begin
                        nxt     = S_LOW;
                        ld_cont = 1'b1;
                    end else begin
                        nxt = S_TAIL;
                    end
                end else begin
                    nxt = S_LOW;
                end
            end
            S_TAIL: if (tick) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_mode <= MODE_LEGACY;
            cur_tx   <= 1'b0;
            cur_half <= HALF_W'(1);
            tmr_q    <= '0;
            bitc_q   <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
        end else begin
            if (ld_idle) begin
                cur_mode <= cfg_mode;
                cur_tx   <= cfg_tx;
                cur_half <= half_eff;
            end
            if (ld_any || state_q == S_IDLE) tmr_q <= '0;
            else                             tmr_q <= tick ? '0 : tmr_q + 1'b1;
            if (ld_any) begin
                tx_sh  <= ld_from_tx ? tx_data : 8'h00;
                bitc_q <= '0;
            end else if (state_q == S_HIGH && tick && !last) begin
                bitc_q <= bitc_q + 1'b1;
                unique case (cur_mode)
                    MODE_QUAD: tx_sh <= {tx_sh[3:0], 4'b0};
                    MODE_DUAL: tx_sh <= {tx_sh[5:0], 2'b0};
                    default:   tx_sh <= {tx_sh[6:0], 1'b0};
                endcase
            end
            if (state_q == S_LOW && tick) begin
                unique case (cur_mode)
                    MODE_QUAD: rx_sh <= {rx_sh[3:0], din};
                    MODE_DUAL: rx_sh <= {rx_sh[5:0], din[1:0]};
                    default:   rx_sh <= {rx_sh[6:0], din[1]};
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        busy     = (state_q != S_IDLE);
        sck      = (state_q == S_HIGH);
        cs_n     = (state_q == S_IDLE);
        sel_mode = busy ? cur_mode : cfg_mode;
        sel_tx   = busy ? cur_tx : cfg_tx;
        unique case (cur_mode)
            MODE_QUAD: dout = tx_sh[7:4];
            MODE_DUAL: dout = {2'b00, tx_sh[7:6]};
            default:   dout = {3'b000, tx_sh[7]};
        endcase
        unique case (sel_mode)
            MODE_QUAD: oe = sel_tx ? 4'b1111 : 4'b0000;
            MODE_DUAL: oe = sel_tx ? 4'b0011 : 4'b0000;
            default:   oe = 4'b0001;
        endcase
    end

    // R13
    dout_rise_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $stable(dout));

    // R10
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> !$past(sck));

    // R7
    hd_rx_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_hd(cur_mode) && !cur_tx) |-> !tx_pop);

    // R9
    hd_rx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_hd(cur_mode) && !cur_tx) |-> (oe == 4'b0000));

    // R11
    half_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (tmr_q < cur_half));

endmodule

// File: rtl/mlspi_master.sv
module mlspi_master
    import mlspi_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int HALF_W = 8,
    parameter int DW     = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          spi_sck,
    output logic          spi_cs_n,
    output logic [3:0]    spi_dout,
    output logic [3:0]    spi_oe,
    input  logic [3:0]    spi_din
);
    localparam int CW = $clog2(DEPTH + 1);

    lane_mode_e        mode_q;
    logic              dir_tx_q;
    logic [HALF_W-1:0] half_q;
    logic [7:0]        rxcnt_q;
    logic              tx_push, tx_pop, tx_full, tx_empty, tx_ovf;
    logic              rx_push, rx_pop, rx_full, rx_empty, rx_ovf;
    logic [7:0]        tx_data, rx_wdata, rx_rdata;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic              rxcnt_dec, busy, ovf_clr;

    assign tx_push = bus_wr && (bus_addr == A_DATA);
    assign rx_pop  = bus_rd && (bus_addr == A_DATA);
    assign ovf_clr = bus_wr && (bus_addr == A_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MODE_LEGACY;
            dir_tx_q <= 1'b0;
            half_q   <= HALF_W'(1);
            rxcnt_q  <= '0;
        end else begin
            if (bus_wr && bus_addr == A_CTRL) begin
                mode_q   <= lane_mode_e'(bus_wdata[1:0]);
                dir_tx_q <= bus_wdata[2];
                half_q   <= bus_wdata[8 +: HALF_W];
            end
            if (bus_wr && bus_addr == A_RXCNT) rxcnt_q <= bus_wdata[7:0];
            else if (rxcnt_dec)                rxcnt_q <= rxcnt_q - 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:  bus_rdata = DW'({half_q, 5'b0, dir_tx_q, mode_q});
            A_DATA:  bus_rdata = DW'(rx_rdata);
            A_RXCNT: bus_rdata = DW'(rxcnt_q);
            default: bus_rdata = DW'({busy, rx_ovf, tx_ovf, rx_cnt, tx_cnt});
        endcase
    end

    mlspi_fifo #(.W(8), .DEPTH(DEPTH), .CW(CW)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(bus_wdata[7:0]),
        .pop(tx_pop), .rdata(tx_data), .count(tx_cnt), .full(tx_full),
        .empty(tx_empty), .ovf_clr(ovf_clr), .ovf(tx_ovf));

    mlspi_fifo #(.W(8), .DEPTH(DEPTH), .CW(CW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_wdata),
        .pop(rx_pop), .rdata(rx_rdata), .count(rx_cnt), .full(rx_full),
        .empty(rx_empty), .ovf_clr(ovf_clr), .ovf(rx_ovf));

    mlspi_engine #(.HALF_W(HALF_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .cfg_mode(mode_q), .cfg_tx(dir_tx_q),
        .cfg_half(half_q), .tx_empty(tx_empty), .tx_data(tx_data),
        .tx_pop(tx_pop), .rxcnt_nz(rxcnt_q != '0), .rxcnt_dec(rxcnt_dec),
        .rx_push(rx_push), .rx_data(rx_wdata), .busy(busy), .sck(spi_sck),
        .cs_n(spi_cs_n), .dout(spi_dout), .oe(spi_oe), .din(spi_din));

    // R7
    rxcnt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rxcnt_dec |-> (rxcnt_q != '0));

    // R12
    tx_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_full && !tx_pop) |=> (tx_cnt == CW'(DEPTH)));

    // R8
    hd_tx_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !spi_cs_n && spi_oe[1] && !rx_full) |-> !rx_push);

endmodule

// File: tb/test_mlspi_master.sv
module test_mlspi_master;
    import mlspi_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        spi_sck, spi_cs_n;
    logic [3:0]  spi_dout, spi_oe, spi_din;

    int tests = 0, fails = 0;
    int blanes = 1;
    logic [7:0]  sl_pat = 8'h00;
    int          sl_idx = 0;
    logic [31:0] sl_rx = '0;
    int nrise = 0, cslow = 0, ncsfall = 0;
    logic [3:0] oe_seen = 4'h0;

    always #2 clk = ~clk;

    mlspi_master i_mlspi_master (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_dout(spi_dout),
        .spi_oe(spi_oe), .spi_din(spi_din));

    // slave model: presents bits before rising edges, advances on falling edges
    always_comb begin
        logic [7:0] cur;
        cur = sl_pat << sl_idx;
        if (blanes == 4)      spi_din = cur[7:4];
        else if (blanes == 2) spi_din = {2'b00, cur[7:6]};
        else                  spi_din = {2'b00, cur[7], 1'b0};
    end

    always @(negedge spi_sck or posedge spi_cs_n) begin
        if (spi_cs_n) sl_idx = 0;
        else          sl_idx = (sl_idx + blanes) % 8;
    end

    always @(posedge spi_sck) begin
        nrise = nrise + 1;
        oe_seen = spi_oe;
        if (blanes == 4)      sl_rx = {sl_rx[27:0], spi_dout};
        else if (blanes == 2) sl_rx = {sl_rx[29:0], spi_dout[1:0]};
        else                  sl_rx = {sl_rx[30:0], spi_dout[0]};
    end

    always @(negedge spi_cs_n) ncsfall = ncsfall + 1;
    always @(negedge clk) if (rst_n && !spi_cs_n) cslow = cslow + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input bit pop, output logic [15:0] d);
        @(negedge clk);
        bus_rd = pop; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_xfer();
        wait (spi_cs_n == 1'b0);
        wait (spi_cs_n == 1'b1);
        repeat (2) @(negedge clk);
    endtask

    typedef struct packed {
        logic [1:0] mode;
        logic       tx;
        logic [7:0] half;
        logic [7:0] mosi;
        logic [7:0] miso;
        logic [3:0] clks;
        logic       cap;
        logic [3:0] oe;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b1, 8'd1, 8'hA5, 8'h3C, 4'd8, 1'b1, 4'h1},
        '{2'd1, 1'b1, 8'd2, 8'h96, 8'hFF, 4'd8, 1'b0, 4'h1},
        '{2'd1, 1'b0, 8'd1, 8'h0F, 8'hC3, 4'd8, 1'b1, 4'h1},
        '{2'd2, 1'b1, 8'd1, 8'h55, 8'h00, 4'd4, 1'b0, 4'h3},
        '{2'd2, 1'b0, 8'd1, 8'h00, 8'h55, 4'd4, 1'b1, 4'h0},
        '{2'd3, 1'b1, 8'd2, 8'hB7, 8'h00, 4'd2, 1'b0, 4'hF},
        '{2'd3, 1'b0, 8'd3, 8'h00, 8'h6E, 4'd2, 1'b1, 4'h0},
        '{2'd0, 1'b0, 8'd1, 8'h81, 8'h7E, 4'd8, 1'b1, 4'h1}
    };

    initial begin
        repeat (200000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual 0x1 expected 0x0");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int r0, c0, f0, h;
        string req;
        bit hdrx;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
        chk(spi_sck == 1'b0, "R1 sck", spi_sck, 0);
        chk(spi_oe == 4'b0001, "R1 oe", spi_oe, 1);
        rd(A_STAT, 0, d);
        chk(d == 16'h0, "R1 status", d, 0);

        // R2 control readback
        wr(A_CTRL, 16'h0506);
        rd(A_CTRL, 0, d);
        chk(d == 16'h0506, "R2 ctrl", d, 16'h0506);
        chk(spi_oe == 4'b0011, "R9 dual tx idle oe", spi_oe, 3);

        // vector table
        for (int i = 0; i < NV; i++) begin
            blanes = (VEC[i].mode == 2'd3) ? 4 : (VEC[i].mode == 2'd2) ? 2 : 1;
            sl_pat = VEC[i].miso;
            hdrx = (VEC[i].mode >= 2'd2) && !VEC[i].tx;
            req = hdrx ? "R7" : (VEC[i].mode == 2'd0) ? "R3" :
                  (VEC[i].mode == 2'd1) ? "R4" : (VEC[i].mode == 2'd2) ? "R5" : "R6";
            wr(A_CTRL, {VEC[i].half, 5'b0, VEC[i].tx, VEC[i].mode});
            r0 = nrise; c0 = cslow;
            if (hdrx) wr(A_RXCNT, 16'd1);
            else      wr(A_DATA, {8'h00, VEC[i].mosi});
            wait_xfer();
            chk(nrise - r0 == int'(VEC[i].clks), req, nrise - r0, VEC[i].clks);
            // R11 and R10 timing
            chk(cslow - c0 == (2 * int'(VEC[i].clks) + 1) * int'(VEC[i].half),
                "R11", cslow - c0, (2 * int'(VEC[i].clks) + 1) * int'(VEC[i].half));
            if (!hdrx)
                chk(sl_rx[7:0] == VEC[i].mosi, req, sl_rx[7:0], VEC[i].mosi);
            chk(oe_seen == VEC[i].oe, "R9", oe_seen, VEC[i].oe);
            rd(A_STAT, 0, d);
            chk(d[5:3] == {2'b00, VEC[i].cap}, VEC[i].cap ? req : "R8", d[5:3], VEC[i].cap);
            if (VEC[i].cap) begin
                rd(A_DATA, 1, d);
                // R13 rising-edge sampling of falling-edge-launched data
                chk(d[7:0] == VEC[i].miso, "R13", d[7:0], VEC[i].miso);
            end
        end

        // R7 / R12: transmit FIFO fill under dual receive, nothing starts
        blanes = 2;
        wr(A_CTRL, 16'h0102);
        f0 = ncsfall;
        wr(A_DATA, 16'h11); wr(A_DATA, 16'h22); wr(A_DATA, 16'h33);
        wr(A_DATA, 16'h44); wr(A_DATA, 16'h99);
        repeat (20) @(negedge clk);
        chk(ncsfall == f0, "R7 no start", ncsfall - f0, 0);
        rd(A_STAT, 0, d);
        chk(d[2:0] == 3'd4, "R12 tx count", d[2:0], 4);
        chk(d[6] == 1'b1, "R12 tx ovf", d[6], 1);
        wr(A_STAT, 16'h0);
        rd(A_STAT, 0, d);
        chk(d[7:6] == 2'b00, "R2 ovf clear", d[7:6], 0);

        // R10: four-word dual transmit burst under one chip select
        r0 = nrise;
        wr(A_CTRL, 16'h0106);
        wait_xfer();
        chk(ncsfall - f0 == 1, "R10 burst cs", ncsfall - f0, 1);
        chk(nrise - r0 == 16, "R5 burst clocks", nrise - r0, 16);
        chk(sl_rx == 32'h11223344, "R5 burst data", sl_rx, 32'h11223344);
        rd(A_STAT, 0, d);
        chk(d[5:0] == 6'd0, "R8 no rx store", d[5:0], 0);

        // R12 / R7: receive overflow with receive count 5
        sl_pat = 8'h5A;
        wr(A_CTRL, 16'h0102);
        r0 = nrise;
        wr(A_RXCNT, 16'd5);
        wait_xfer();
        chk(nrise - r0 == 20, "R7 rx burst clocks", nrise - r0, 20);
        rd(A_RXCNT, 0, d);
        chk(d == 16'd0, "R7 rxcnt drained", d, 0);
        rd(A_STAT, 0, d);
        chk(d[5:3] == 3'd4, "R12 rx count", d[5:3], 4);
        chk(d[7] == 1'b1, "R12 rx ovf", d[7], 1);
        for (int k = 0; k < 4; k++) begin
            rd(A_DATA, 1, d);
            chk(d[7:0] == 8'h5A, "R5 dual rx data", d[7:0], 8'h5A);
        end

        // R11: half-period 0 behaves as 1
        blanes = 1;
        wr(A_CTRL, 16'h0004);
        c0 = cslow;
        wr(A_DATA, 16'h3C);
        wait_xfer();
        h = cslow - c0;
        chk(h == 17, "R11 zero divisor", h, 17);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule